// File: doc/BRIEF.md
# Tri-State PWM Gate-Drive Sequencer

This block sits between a buck controller and the two gate drivers of one synchronous buck phase. It takes the controller's PWM command, already split by comparators into a "high" flag and a "mid-window" flag, and produces the high-side (GH) and low-side (GL) gate enables. A high command turns GH on and a low command turns GL on. A mid command is acted on only after it has lasted a separate hold-off time for each gate. After the hold-off, mid either switches both gates off, or, when diode emulation is enabled, passes control of GL to a zero-cross comparator so that the low-side switch stops conducting once inductor current reaches zero.

Every turn-on waits for the opposite gate's "discharged" feedback to stay true for a set number of cycles. This keeps both gates from being on together and gives a minimum dead time. An active-low disable and a supply-good flag force both gates off without waiting for a clock edge. After either one is released, the block waits for a real high or low command before it enables anything. A thermal warning output with hysteresis reports over-temperature and does not stop the switching.

Top module: `tri_pwm_gate_seq`

## Requirements
- R1: With pwm_mid=0 and pwm_hi=1 (high command), GL goes off on the 2nd clock edge. GH comes on on edge DEAD_CYC+3 after the command, once GL has been off with gl_low_fb=1 for DEAD_CYC edges.
- R2: With pwm_mid=0 and pwm_hi=0 (low command), GH goes off on the 2nd edge. GL comes on once gh_low_fb has been true for DEAD_CYC edges, which is edge DEAD_CYC+3 when leaving a high command.
- R3: A mid command (pwm_mid=1) leaves GH unchanged for GH_HOLD_CYC+1 edges and turns GH off on edge GH_HOLD_CYC+2.
- R4: With diode emulation off (dem_n=1), a mid command leaves GL unchanged for GL_HOLD_CYC+1 edges and turns it off on edge GL_HOLD_CYC+2.
- R5: With diode emulation on (dem_n=0), once the GL hold-off of a mid command has passed, GL is on while zc_flag=0 (current positive) and goes off 2 edges after zc_flag=1 (current at or below zero). It then stays off, even if zc_flag returns to 0, until the next low command.
- R6: Leaving the mid window before its hold-off expires restarts the hold-off count, and the gates follow the new high or low command.
- R7: dis_n=0 forces gh_en and gl_en to 0 in the same cycle, whatever the other inputs are. After dis_n returns to 1, no gate turns on until a high or low command is seen.
- R8: sup_ok=0 forces both enables to 0 in the same cycle and holds them there. After sup_ok returns to 1, no gate turns on until a high or low command is seen.
- R9: gh_en and gl_en are never 1 together. A gate cannot turn on while the opposite gate's low feedback (gh_low_fb or gl_low_fb, 1 = discharged) is 0.
- R10: therm_warn is set 1 edge after ot_hot=1 and cleared 1 edge after ot_cool=1 when ot_hot=0. It holds its value while both flags are 0, and switching continues while it is set.
- R11: During and after reset both enables and therm_warn are 0, and a mid command alone enables neither gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 1 | PWM above the upper threshold |
| pwm_mid | input | 1 | PWM inside the tri-state window (overrides pwm_hi) |
| dis_n | input | 1 | Active-low disable |
| dem_n | input | 1 | Active-low diode-emulation enable |
| zc_flag | input | 1 | Inductor current at or below zero |
| sup_ok | input | 1 | Supply above lockout threshold |
| ot_hot | input | 1 | Junction above warning-set temperature |
| ot_cool | input | 1 | Junction below warning-clear temperature |
| gh_low_fb | input | 1 | High-side gate discharged |
| gl_low_fb | input | 1 | Low-side gate discharged |
| gh_en | output | 1 | High-side gate enable |
| gl_en | output | 1 | Low-side gate enable |
| therm_warn | output | 1 | Thermal warning flag |

## Verification
A command change reaches its gate target register on the first edge, and a gate turns off on the second. Turn-on needs DEAD_CYC more edges of settled feedback, plus one edge to act on it. The end of a hold-off adds the hold count plus two edges, the warning takes one edge, and disable and lockout act combinationally within the same cycle. The bench drives inputs on the falling edge and samples on a later falling edge, after exactly the number of rising edges stated in each requirement. For each timing it checks both the edge before the change and the edge on which the change is due.

// File: rtl/tri_pwm_gate_seq.sv
module tri_pwm_gate_seq #(
  parameter int unsigned GH_HOLD_CYC = 7,
  parameter int unsigned GL_HOLD_CYC = 26,
  parameter int unsigned DEAD_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_hi,
  input  logic pwm_mid,
  input  logic dis_n,
  input  logic dem_n,
  input  logic zc_flag,
  input  logic sup_ok,
  input  logic ot_hot,
  input  logic ot_cool,
  input  logic gh_low_fb,
  input  logic gl_low_fb,
  output logic gh_en,
  output logic gl_en,
  output logic therm_warn
);

  localparam int unsigned MID_MAX = (GL_HOLD_CYC > GH_HOLD_CYC) ? GL_HOLD_CYC : GH_HOLD_CYC;
  localparam int unsigned MID_W   = $clog2(MID_MAX + 2);
  localparam int unsigned DEAD_W  = $clog2(DEAD_CYC + 2);

  logic              live;
  logic [MID_W-1:0]  mid_cnt;
  logic              gh_exp, gl_exp;
  logic              armed, tgt_gh, tgt_gl, zc_lat;
  logic              gh_q, gl_q;
  logic [DEAD_W-1:0] gh_off_cnt, gl_off_cnt;
  logic              gh_clear, gl_clear;

  assign live     = dis_n & sup_ok;
  assign gh_exp   = mid_cnt >= MID_W'(GH_HOLD_CYC);
  assign gl_exp   = mid_cnt >= MID_W'(GL_HOLD_CYC);
  assign gh_clear = gh_off_cnt == DEAD_W'(DEAD_CYC);
  assign gl_clear = gl_off_cnt == DEAD_W'(DEAD_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            mid_cnt <= '0;
    else if (!live || !pwm_mid)            mid_cnt <= '0;
    else if (mid_cnt != MID_W'(MID_MAX))   mid_cnt <= mid_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; tgt_gh <= 1'b0; tgt_gl <= 1'b0; zc_lat <= 1'b0;
    end else if (!live) begin
      armed <= 1'b0; tgt_gh <= 1'b0; tgt_gl <= 1'b0; zc_lat <= 1'b0;
    end else if (!pwm_mid) begin
      armed  <= 1'b1;
      tgt_gh <= pwm_hi;
      tgt_gl <= !pwm_hi;
      if (!pwm_hi) zc_lat <= 1'b0;
    end else if (armed) begin
      if (gh_exp || gl_exp) tgt_gh <= 1'b0;
      if (gl_exp) begin
        if (dem_n) tgt_gl <= 1'b0;
        else begin
          tgt_gl <= !zc_flag && !zc_lat;
          if (zc_flag) zc_lat <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh_off_cnt <= '0; gl_off_cnt <= '0;
    end else begin
      if (!live || gh_q || !gh_low_fb) gh_off_cnt <= '0;
      else if (!gh_clear)              gh_off_cnt <= gh_off_cnt + 1'b1;
      if (!live || gl_q || !gl_low_fb) gl_off_cnt <= '0;
      else if (!gl_clear)              gl_off_cnt <= gl_off_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh_q <= 1'b0; gl_q <= 1'b0;
    end else begin
      gh_q <= live && tgt_gh && !tgt_gl && (gh_q || (!gl_q && gl_clear));
      gl_q <= live && tgt_gl && !tgt_gh && (gl_q || (!gh_q && gh_clear));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       therm_warn <= 1'b0;
    else if (ot_hot)  therm_warn <= 1'b1;
    else if (ot_cool) therm_warn <= 1'b0;
  end

  assign gh_en = gh_q & live;
  assign gl_en = gl_q & live;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(gh_en && gl_en)); // R9
  AST_GH_WAITS_FB: assert property (@(posedge clk) disable iff (!rst_n) $rose(gh_q) |-> !$past(gl_q) && $past(gl_low_fb, 2)); // R9
  AST_GL_WAITS_FB: assert property (@(posedge clk) disable iff (!rst_n) $rose(gl_q) |-> !$past(gh_q) && $past(gh_low_fb, 2)); // R9
  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !dis_n |=> !gh_q && !gl_q); // R7
  AST_SUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !sup_ok |=> !gh_q && !gl_q); // R8
  AST_WARN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!ot_hot && !ot_cool) |=> $stable(therm_warn)); // R10
  AST_WARN_SETS: assert property (@(posedge clk) disable iff (!rst_n) ot_hot |=> therm_warn); // R10
  AST_MID_NO_GH_ON: assert property (@(posedge clk) disable iff (!rst_n) (pwm_mid && $past(pwm_mid) && !gh_q) |=> !gh_q); // R3

endmodule

// File: tb/tri_pwm_gate_seq_bench.sv
module tri_pwm_gate_seq_bench;
  localparam int GH_H = 7;
  localparam int GL_H = 26;
  localparam int DT   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_hi = 1'b0, pwm_mid = 1'b1, dis_n = 1'b1, dem_n = 1'b1, zc_flag = 1'b0;
  logic sup_ok = 1'b1, ot_hot = 1'b0, ot_cool = 1'b0, gl_stuck = 1'b0;
  logic gh_low_fb, gl_low_fb, gh_en, gl_en, therm_warn;
  int checks = 0, errors = 0, overlaps = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign gh_low_fb = !gh_en;
  assign gl_low_fb = !gl_en && !gl_stuck;

  tri_pwm_gate_seq #(.GH_HOLD_CYC(GH_H), .GL_HOLD_CYC(GL_H), .DEAD_CYC(DT)) u_tri_pwm_gate_seq (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_mid(pwm_mid), .dis_n(dis_n),
    .dem_n(dem_n), .zc_flag(zc_flag), .sup_ok(sup_ok), .ot_hot(ot_hot), .ot_cool(ot_cool),
    .gh_low_fb(gh_low_fb), .gl_low_fb(gl_low_fb), .gh_en(gh_en), .gl_en(gl_en),
    .therm_warn(therm_warn));

  always @(negedge clk) if (rst_n && gh_en && gl_en) overlaps++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic hi, input logic mid);
    pwm_hi = hi; pwm_mid = mid;
  endtask

  task automatic settle_low();  cmd(1'b0, 1'b0); step(DT + 8); endtask
  task automatic settle_high(); cmd(1'b1, 1'b0); step(DT + 8); endtask

  task automatic t_reset();
    chk("R11", "gh in reset", gh_en, 1'b0);
    chk("R11", "gl in reset", gl_en, 1'b0);
    chk("R11", "warn in reset", therm_warn, 1'b0);
    rst_n = 1'b1;
    step(GL_H + 10);
    chk("R11", "gh mid only", gh_en, 1'b0);
    chk("R11", "gl mid only", gl_en, 1'b0);
  endtask

  task automatic t_low_from_idle();
    cmd(1'b0, 1'b0);
    step(1);
    chk("R2", "gl edge1", gl_en, 1'b0);
    step(1);
    chk("R2", "gl edge2", gl_en, 1'b1);
    chk("R2", "gh stays off", gh_en, 1'b0);
  endtask

  task automatic t_high_then_low();
    settle_low();
    cmd(1'b1, 1'b0);
    step(1);
    chk("R1", "gl still on edge1", gl_en, 1'b1);
    step(1);
    chk("R1", "gl off edge2", gl_en, 1'b0);
    step(DT);
    chk("R1", "gh dead time", gh_en, 1'b0);
    step(1);
    chk("R1", "gh on", gh_en, 1'b1);
    step(5);
    cmd(1'b0, 1'b0);
    step(2);
    chk("R2", "gh off edge2", gh_en, 1'b0);
    step(DT);
    chk("R2", "gl dead time", gl_en, 1'b0);
    step(1);
    chk("R2", "gl on", gl_en, 1'b1);
  endtask

  task automatic t_mid_holdoff();
    dem_n = 1'b1;
    settle_high();
    cmd(1'b0, 1'b1);
    step(GH_H + 1);
    chk("R3", "gh before holdoff", gh_en, 1'b1);
    step(1);
    chk("R3", "gh after holdoff", gh_en, 1'b0);
    step(GL_H);
    chk("R4", "gl stays off from high", gl_en, 1'b0);
    settle_low();
    cmd(1'b0, 1'b1);
    step(GL_H + 1);
    chk("R4", "gl before holdoff", gl_en, 1'b1);
    step(1);
    chk("R4", "gl after holdoff", gl_en, 1'b0);
    chk("R4", "gh off", gh_en, 1'b0);
  endtask

  task automatic t_dem();
    settle_low();
    dem_n = 1'b0; zc_flag = 1'b0;
    settle_high();
    cmd(1'b0, 1'b1);
    step(GL_H + 1);
    chk("R5", "gl before holdoff", gl_en, 1'b0);
    step(1);
    chk("R5", "gl on positive current", gl_en, 1'b1);
    zc_flag = 1'b1;
    step(1);
    chk("R5", "gl edge1 after zc", gl_en, 1'b1);
    step(1);
    chk("R5", "gl off after zc", gl_en, 1'b0);
    zc_flag = 1'b0;
    step(6);
    chk("R5", "gl latched off", gl_en, 1'b0);
    cmd(1'b0, 1'b0);
    step(2);
    chk("R5", "gl back on low", gl_en, 1'b1);
    dem_n = 1'b1;
  endtask

  task automatic t_early_exit();
    settle_low();
    cmd(1'b0, 1'b1);
    step(GL_H - 2);
    cmd(1'b0, 1'b0);
    step(1);
    cmd(1'b0, 1'b1);
    step(GL_H - 2);
    chk("R6", "gl kept, count restarted", gl_en, 1'b1);
    settle_high();
    cmd(1'b0, 1'b1);
    step(3);
    chk("R6", "gh kept in short mid", gh_en, 1'b1);
    cmd(1'b0, 1'b0);
    step(DT + 3);
    chk("R6", "gl follows new low", gl_en, 1'b1);
    chk("R6", "gh off on new low", gh_en, 1'b0);
  endtask

  task automatic t_disable();
    settle_high();
    dis_n = 1'b0;
    #1;
    chk("R7", "gh off same cycle", gh_en, 1'b0);
    step(3);
    cmd(1'b0, 1'b1);
    dis_n = 1'b1;
    step(GL_H + 6);
    chk("R7", "gh waits for command", gh_en, 1'b0);
    chk("R7", "gl waits for command", gl_en, 1'b0);
    cmd(1'b1, 1'b0);
    step(DT + 4);
    chk("R7", "gh after command", gh_en, 1'b1);
  endtask

  task automatic t_supply();
    settle_low();
    sup_ok = 1'b0;
    #1;
    chk("R8", "gl off same cycle", gl_en, 1'b0);
    step(5);
    chk("R8", "gl held off", gl_en, 1'b0);
    cmd(1'b0, 1'b1);
    sup_ok = 1'b1;
    step(GL_H + 6);
    chk("R8", "gl waits for command", gl_en, 1'b0);
    cmd(1'b0, 1'b0);
    step(DT + 4);
    chk("R8", "gl after command", gl_en, 1'b1);
  endtask

  task automatic t_interlock();
    settle_low();
    gl_stuck = 1'b1;
    cmd(1'b1, 1'b0);
    step(20);
    chk("R9", "gh blocked by gl feedback", gh_en, 1'b0);
    gl_stuck = 1'b0;
    step(DT + 1);
    chk("R9", "gh after feedback clears", gh_en, 1'b1);
  endtask

  task automatic t_thermal();
    settle_high();
    ot_hot = 1'b1;
    step(1);
    chk("R10", "warn set", therm_warn, 1'b1);
    ot_hot = 1'b0;
    step(4);
    chk("R10", "warn held", therm_warn, 1'b1);
    chk("R10", "gh still switching", gh_en, 1'b1);
    cmd(1'b0, 1'b0);
    step(DT + 3);
    chk("R10", "gl on while warn", gl_en, 1'b1);
    ot_cool = 1'b1;
    step(1);
    chk("R10", "warn clear", therm_warn, 1'b0);
    ot_cool = 1'b0;
  endtask

  initial begin
    step(3);
    t_reset();
    t_low_from_idle();
    t_high_then_low();
    t_mid_holdoff();
    t_dem();
    t_early_exit();
    t_disable();
    t_supply();
    t_interlock();
    t_thermal();
    checks++;
    if (overlaps != 0) begin
      errors++;
      $display("FAIL R9 overlap cycles actual=%0d expected=0", overlaps);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule